// File: doc/BRIEF.md
# One-Time-Programmable Security Register Model

This block is a synthesizable behavioural stand-in for the security area of a 16-bit, command-driven flash part, meant as a target for driver and system tests. Software writes commands to word address 0 and then reads or programs a 128-bit security register and a lock word. The register is organised as eight 16-bit words. The lower four words hold a factory identifier that is fixed by a parameter. The upper four words are a user segment that can be programmed.

Programming follows flash rules: a bit can only be cleared, never set again. A program takes a configurable number of busy cycles. Afterwards the block reports a status word until software returns it to array mode.

The lock word is written once. Clearing its bit 0 freezes the user segment for good. A program that the rules refuse changes nothing and raises the protect flag in the status word.

The control is one state machine with five states:
- ARRAY is the idle mode.
- IDENT maps the security words for reading.
- ARMED waits for the program write.
- BUSY counts down the program time.
- STATUS holds the result.

Its transitions are:
- command 0x0090 at address 0 goes from ARRAY or IDENT to IDENT;
- command 0x00FF at address 0 goes from ARRAY or IDENT to ARRAY;
- command 0x00C0 at address 0 goes from ARRAY or IDENT to ARMED;
- any write in ARMED goes to BUSY;
- the end of the countdown goes from BUSY to STATUS;
- command 0x00FF at address 0 goes from STATUS to ARRAY.

Top module: `prm_otp_model`

## Requirements
- R1: After reset the block is in ARRAY mode and reads return 0xFFFF. In IDENT mode the lock word and the four user words read 0xFFFF, and factory word k reads FACTORY_ID bits [63-16k -: 16], so address 0x81 gives the top 16 bits.
- R2: In ARRAY and IDENT modes, only writes to address 0 with data 0x0090 (go to IDENT), 0x00FF (go to ARRAY) or 0x00C0 (go to ARMED) have any effect. All other data values and all other addresses are ignored.
- R3: In IDENT mode, the read address selects the data:
  - address 0x80 returns the lock word;
  - addresses 0x81 to 0x84 return the factory words;
  - addresses 0x85 to 0x88 return the user words;
  - any other address returns 0xFFFF.
- R4: In ARMED, BUSY and STATUS modes, reads at any address return the status word. Bit 7 is ready, bit 1 is protect, and all other bits are 0. In ARMED the next write, at any address, is the program operation.
- R5: The ready bit reads 0 for exactly BUSY_CYCLES cycles, starting with the cycle after the clock edge that accepts the program write. It then reads 1 in STATUS mode.
- R6: A permitted program replaces the target word with old AND data, so no bit ever goes from 0 to 1. The result is applied when the busy time ends.
- R7: A program aimed at a factory word (0x81 to 0x84) sets the protect bit and leaves every word unchanged.
- R8: Once bit 0 of the lock word is 0, a program aimed at a user word (0x85 to 0x88) sets the protect bit and leaves the word unchanged.
- R9: The first program of the lock word (0x80) is applied. Any later program of the lock word sets the protect bit and leaves the lock word unchanged.
- R10: Writes in BUSY mode are ignored, including 0x00FF. In STATUS mode only 0x00FF at address 0 has an effect, returning the block to ARRAY mode.
- R11: A program aimed at an address outside 0x80 to 0x88 sets the protect bit. Accepting command 0x00C0 clears the protect bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 16 | Write data or command code |
| rd_addr | input | 8 | Word address of the read |
| rd_data | output | 16 | Read data, combinational from state and rd_addr |

## Verification
The reads are combinational from registered state, so a write applied after one rising edge shows up on rd_data once the next edge has captured it. The bench drives its inputs just after a rising edge and samples rd_data on the falling edge that follows. A behavioural reference model is updated on each rising edge and compared with rd_data on every falling edge.

A program write moves the block into BUSY on the edge that accepts it. Ready then stays low for exactly BUSY_CYCLES falling-edge samples, and the new word value and the protect flag appear together on the edge that leaves BUSY. The bench counts these cycles explicitly, using BUSY_CYCLES=5.

// File: rtl/prm_pkg.sv
package prm_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_IDENT,
        ST_ARMED,
        ST_BUSY,
        ST_STATUS
    } prm_state_e;

    localparam logic [15:0] CMD_IDENT = 16'h0090;
    localparam logic [15:0] CMD_PROG  = 16'h00C0;
    localparam logic [15:0] CMD_ARRAY = 16'h00FF;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_PROT_BIT  = 1;

endpackage

// File: rtl/prm_cmd_fsm.sv
module prm_cmd_fsm
    import prm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output prm_state_e        state_q,
    output logic              arm,
    output logic              capture,
    output logic              commit
);

    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    prm_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cmd_hit;
    logic             cnt_zero;

    assign cmd_hit  = wr_en && (wr_addr == '0);
    assign cnt_zero = (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY, ST_IDENT: begin
                if (cmd_hit) begin
                    if (wr_data == DATA_W'(CMD_IDENT))      state_d = ST_IDENT;
                    else if (wr_data == DATA_W'(CMD_PROG))  state_d = ST_ARMED;
                    else if (wr_data == DATA_W'(CMD_ARRAY)) state_d = ST_ARRAY;
                end
            end
            ST_ARMED: begin
                if (wr_en) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (cnt_zero) state_d = ST_STATUS;
            end
            ST_STATUS: begin
                if (cmd_hit && wr_data == DATA_W'(CMD_ARRAY)) state_d = ST_ARRAY;
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARRAY;
        else        state_q <= state_d;
    end

    // busy countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (capture)                     cnt_q <= CNT_W'(BUSY_CYCLES - 1);
        else if (state_q == ST_BUSY && !cnt_zero) cnt_q <= cnt_q - 1'b1;
    end

    // output strobes
    always_comb begin
        arm     = 1'b0;
        capture = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_ARRAY, ST_IDENT: arm = cmd_hit && (wr_data == DATA_W'(CMD_PROG));
            ST_ARMED:           capture = wr_en;
            ST_BUSY:            commit = cnt_zero;
            ST_STATUS:          ;
            default:            ;
        endcase
    end

    p_busy_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state_q == ST_BUSY));

    p_commit_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_STATUS));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATUS && !(cmd_hit && wr_data == DATA_W'(CMD_ARRAY)))
        |=> (state_q == ST_STATUS));

    p_busy_deaf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !cnt_zero) |=> (state_q == ST_BUSY));

endmodule

// File: rtl/prm_store.sv
module prm_store #(
    parameter int                           ADDR_W     = 8,
    parameter int                           DATA_W     = 16,
    parameter int                           SEG_WORDS  = 4,
    parameter int                           LOCK_ADDR  = 'h80,
    parameter logic [SEG_WORDS*DATA_W-1:0]  FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              capture,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] ident_word,
    output logic              prot_q
);

    localparam int PR_BASE   = LOCK_ADDR + 1;
    localparam int USER_BASE = PR_BASE + SEG_WORDS;
    localparam int PR_END    = USER_BASE + SEG_WORDS;
    localparam int TOT_WORDS = 2 * SEG_WORDS;

    logic [ADDR_W-1:0]           pend_addr_q;
    logic [DATA_W-1:0]           pend_data_q;
    logic [DATA_W-1:0]           lock_q;
    logic                        lock_used_q;
    logic [SEG_WORDS*DATA_W-1:0] user_flat;
    logic                        is_lock, is_fac, is_user, allow;
    int                          pend_i;

    // pending program operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr_q <= '0;
            pend_data_q <= '1;
        end else if (capture) begin
            pend_addr_q <= wr_addr;
            pend_data_q <= wr_data;
        end
    end

    // permission decode
    always_comb begin
        pend_i  = int'(pend_addr_q);
        is_lock = (pend_i == LOCK_ADDR);
        is_fac  = (pend_i >= PR_BASE) && (pend_i < USER_BASE);
        is_user = (pend_i >= USER_BASE) && (pend_i < PR_END);
        allow   = (is_lock && !lock_used_q) || (is_user && lock_q[0]);
    end

    // lock word, programmable once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q      <= '1;
            lock_used_q <= 1'b0;
        end else if (commit && allow && is_lock) begin
            lock_q      <= lock_q & pend_data_q;
            lock_used_q <= 1'b1;
        end
    end

    // user words
    for (genvar i = 0; i < SEG_WORDS; i++) begin : g_user
        logic [DATA_W-1:0] word_q;
        logic              hit;
        assign hit = is_user && (pend_i == USER_BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   word_q <= '1;
            else if (commit && allow && hit) word_q <= word_q & pend_data_q;
        end
        assign user_flat[i*DATA_W +: DATA_W] = word_q;
    end

    // protect flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                prot_q <= 1'b0;
        else if (arm)              prot_q <= 1'b0;
        else if (commit && !allow) prot_q <= 1'b1;
    end

    // identifier-mode read
    always_comb begin
        ident_word = '1;
        if (int'(rd_addr) == LOCK_ADDR) ident_word = lock_q;
        for (int i = 0; i < TOT_WORDS; i++) begin
            if (int'(rd_addr) == PR_BASE + i) begin
                if (i < SEG_WORDS)
                    ident_word = FACTORY_ID[(SEG_WORDS-1-i)*DATA_W +: DATA_W];
                else
                    ident_word = user_flat[(i-SEG_WORDS)*DATA_W +: DATA_W];
            end
        end
    end

    p_factory_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && is_fac) |=> (prot_q && $stable(user_flat) && $stable(lock_q)));

    p_user_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !lock_q[0]) |=> $stable(user_flat));

    p_lock_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lock_used_q) |=> $stable(lock_q));

    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (((user_flat & ~$past(user_flat)) == '0) &&
                    ((lock_q & ~$past(lock_q)) == '0)));

    p_prot_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !prot_q);

    p_quiet_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(user_flat) && $stable(lock_q)));

endmodule

// File: rtl/prm_otp_model.sv
module prm_otp_model
    import prm_pkg::*;
#(
    parameter int                     ADDR_W      = 8,
    parameter int                     DATA_W      = 16,
    parameter int                     SEG_WORDS   = 4,
    parameter int                     BUSY_CYCLES = 4,
    parameter int                     LOCK_ADDR   = 'h80,
    parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = 64'h1234_5678_9ABC_DEF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    prm_state_e        state_q;
    logic              arm, capture, commit;
    logic [DATA_W-1:0] ident_word;
    logic              prot_q;
    logic [DATA_W-1:0] status_word;

    prm_cmd_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state_q (state_q),
        .arm     (arm),
        .capture (capture),
        .commit  (commit)
    );

    prm_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SEG_WORDS  (SEG_WORDS),
        .LOCK_ADDR  (LOCK_ADDR),
        .FACTORY_ID (FACTORY_ID)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .capture    (capture),
        .commit     (commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .ident_word (ident_word),
        .prot_q     (prot_q)
    );

    always_comb begin
        status_word                 = '0;
        status_word[STAT_READY_BIT] = (state_q != ST_BUSY);
        status_word[STAT_PROT_BIT]  = prot_q;
    end

    always_comb begin
        unique case (state_q)
            ST_ARRAY:                     rd_data = '1;
            ST_IDENT:                     rd_data = ident_word;
            ST_ARMED, ST_BUSY, ST_STATUS: rd_data = status_word;
            default:                      rd_data = '1;
        endcase
    end

    p_ready_low_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (rd_data[STAT_READY_BIT] == 1'b0));

endmodule

// File: tb/prm_otp_model_tb.sv
module prm_otp_model_tb;

    localparam int CLK_P = 10;
    localparam int BUSY  = 5;
    localparam logic [63:0] FAC_ID = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_mode = 0;          // 0 array, 1 ident, 2 armed, 3 busy, 4 status
    int m_cnt = 0;
    int m_lock = 'hFFFF;
    int m_used = 0;
    int m_prot = 0;
    int m_user[4] = '{'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF};
    int p_addr = 0;
    int p_data = 0;

    always #(CLK_P/2) clk = ~clk;

    prm_otp_model #(
        .BUSY_CYCLES (BUSY),
        .FACTORY_ID  (FAC_ID)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic int expect_read(int a);
        int r;
        if (m_mode == 0) return 'hFFFF;
        if (m_mode == 1) begin
            r = 'hFFFF;
            if (a == 'h80) r = m_lock;
            else if (a >= 'h81 && a <= 'h84) r = int'(FAC_ID[(3-(a-'h81))*16 +: 16]);
            else if (a >= 'h85 && a <= 'h88) r = m_user[a-'h85];
            return r;
        end
        return ((m_mode != 3) ? 'h80 : 0) | (m_prot ? 'h02 : 0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_lock = 'hFFFF; m_used = 0; m_prot = 0;
            for (int i = 0; i < 4; i++) m_user[i] = 'hFFFF;
        end else begin
            case (m_mode)
                0, 1: if (wr_en && wr_addr == 0) begin
                    if (wr_data == 16'h0090) m_mode = 1;
                    else if (wr_data == 16'h00FF) m_mode = 0;
                    else if (wr_data == 16'h00C0) begin m_mode = 2; m_prot = 0; end
                end
                2: if (wr_en) begin
                    p_addr = int'(wr_addr); p_data = int'(wr_data);
                    m_mode = 3; m_cnt = BUSY;
                end
                3: begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        m_mode = 4;
                        if (p_addr == 'h80 && m_used == 0) begin
                            m_lock = m_lock & p_data; m_used = 1;
                        end else if (p_addr >= 'h85 && p_addr <= 'h88 && (m_lock & 1) == 1)
                            m_user[p_addr-'h85] = m_user[p_addr-'h85] & p_data;
                        else
                            m_prot = 1;
                    end
                end
                4: if (wr_en && wr_addr == 0 && wr_data == 16'h00FF) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (int'(rd_data) != expect_read(int'(rd_addr))) begin
                n_errors++;
                $display("FAIL %s model compare: got %h expected %h", cur_req, rd_data,
                         16'(expect_read(int'(rd_addr))));
            end
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_wr(logic [7:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [15:0] exp, string tag);
        rd_addr = a;
        @(negedge clk);
        chk(tag, rd_data, exp);
    endtask

    task automatic wait_done();
        repeat (BUSY + 1) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got hung expected completion");
        finish_run();
    end

    initial begin
        rd_addr = 8'h81;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        rd_chk(8'h81, 16'hFFFF, "R1 array read after reset");
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h80, 16'hFFFF, "R1 lock after reset");
        rd_chk(8'h81, 16'h1234, "R1 factory word 0");
        rd_chk(8'h84, 16'hDEF0, "R1 factory word 3");
        rd_chk(8'h88, 16'hFFFF, "R1 user word 3");
        cur_req = "R3";
        rd_chk(8'h89, 16'hFFFF, "R3 above map");
        rd_chk(8'h7F, 16'hFFFF, "R3 below map");
        rd_chk(8'h83, 16'h9ABC, "R3 factory word 2");

        cur_req = "R2";
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h03, 16'h0090);
        rd_chk(8'h81, 16'hFFFF, "R2 command at nonzero address ignored");
        do_wr(8'h00, 16'h0055);
        rd_chk(8'h81, 16'hFFFF, "R2 unknown command ignored");
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h82, 16'h5678, "R2 ident entered");

        cur_req = "R4";
        do_wr(8'h00, 16'h00C0);
        rd_chk(8'h82, 16'h0080, "R4 armed status");
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 8'h86; wr_data = 16'h0FF0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        cur_req = "R5";
        for (int k = 0; k < BUSY; k++) begin
            @(negedge clk);
            chk("R5 ready low while busy", {15'b0, rd_data[7]}, 16'h0000);
            if (k == 1) begin
                // R10: array command during busy must be ignored
                @(posedge clk); #1;
                wr_en = 1'b1; wr_addr = 8'h00; wr_data = 16'h00FF;
                k++;
                @(negedge clk);
                chk("R5 ready low while busy", {15'b0, rd_data[7]}, 16'h0000);
                @(posedge clk); #1;
                wr_en = 1'b0;
            end else begin
                @(posedge clk); #1;
            end
        end
        rd_chk(8'h86, 16'h0080, "R5 ready after busy");

        cur_req = "R10";
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h86, 16'h0080, "R10 ident ignored in status");
        do_wr(8'h00, 16'h00C0);
        rd_chk(8'h86, 16'h0080, "R10 program command ignored in status");
        do_wr(8'h00, 16'h00FF);
        rd_chk(8'h86, 16'hFFFF, "R10 array after 0xFF");

        cur_req = "R6";
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h86, 16'h0FF0, "R6 user word programmed");
        do_wr(8'h00, 16'h00C0);
        do_wr(8'h86, 16'hF00F);
        wait_done();
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h86, 16'h0000, "R6 AND semantics");

        cur_req = "R7";
        do_wr(8'h00, 16'h00C0);
        do_wr(8'h82, 16'h0000);
        wait_done();
        rd_chk(8'h82, 16'h0082, "R7 factory program denied");
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h82, 16'h5678, "R7 factory word unchanged");

        cur_req = "R11";
        do_wr(8'h00, 16'h00C0);
        rd_chk(8'h00, 16'h0080, "R11 protect cleared by arming");
        do_wr(8'h20, 16'h0000);
        wait_done();
        rd_chk(8'h00, 16'h0082, "R11 out-of-range program denied");
        do_wr(8'h00, 16'h00FF);

        cur_req = "R9";
        do_wr(8'h00, 16'h00C0);
        do_wr(8'h80, 16'hFFFE);
        wait_done();
        rd_chk(8'h00, 16'h0080, "R9 first lock program accepted");
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h80, 16'hFFFE, "R9 lock word value");

        cur_req = "R8";
        do_wr(8'h00, 16'h00C0);
        do_wr(8'h87, 16'h0000);
        wait_done();
        rd_chk(8'h00, 16'h0082, "R8 locked user program denied");
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h87, 16'hFFFF, "R8 locked user word unchanged");

        cur_req = "R9";
        do_wr(8'h00, 16'h00C0);
        do_wr(8'h80, 16'h0000);
        wait_done();
        rd_chk(8'h00, 16'h0082, "R9 second lock program denied");
        do_wr(8'h00, 16'h00FF);
        do_wr(8'h00, 16'h0090);
        rd_chk(8'h80, 16'hFFFE, "R9 lock word unchanged");

        repeat (2) @(posedge clk);
        #1;
        finish_run();
    end

endmodule